// File: doc/BRIEF.md
# Receive Byte-Match Unit

This unit watches the stream of bytes that the receive DMA engine moves from the receive FIFO into memory. Each byte is compared with a small bank of programmable candidate values. A candidate takes part only while its enable bit is set. When an enabled candidate equals the byte, the unit pulses that candidate's event output and sets its sticky event flag. It also copies the running receive and transmit byte counts that came with the byte into two amount registers.

Each candidate has a one-shot bit that turns it off after its first hit. Two shortcut bits per candidate act on a hit. The chain bit turns on candidate (i+1) mod N, and the self bit turns candidate i off. Software can also turn single candidates on or off with enable and disable task pulses. With these, single-byte comparators can be strung into detectors for multi-byte sequences.

A two-state machine drives the unit. In ST_WAIT it captures the byte and its counts when `byte_valid` is high, then moves to ST_APPLY. In ST_APPLY it evaluates the candidates and commits the results. It goes back to ST_WAIT if no new byte arrives, and stays in ST_APPLY if one does.

Candidates are evaluated in ascending index order within one byte. A candidate that a lower-index chain has just turned on can therefore hit on the same byte.

Top module: `rx_byte_match`

## Requirements
- R1: After reset, `match_en`, `evt_flags`, `evt_pulse`, `irq`, `rx_amount` and `tx_amount` are all zero.
- R2: A byte presented with `byte_valid` in cycle k is evaluated in cycle k+1. In that cycle `evt_pulse[i]` is high exactly for the candidates that are enabled at their turn and whose value equals the byte. A disabled candidate never pulses, and `evt_pulse` is zero in every other cycle.
- R3: When a byte hits at least one candidate, `rx_amount` and `tx_amount` take the `rx_count` and `tx_count` values sampled with that byte, one edge after the evaluation cycle. A byte with no hit leaves both unchanged.
- R4: A hit on candidate i whose one-shot bit is set clears enable bit i.
- R5: A hit sets `evt_flags[i]`. The flag stays set until a cycle with `evt_clr[i]` high and no new hit on i. `irq` is the OR over i of `evt_flags[i]` AND irq mask bit i.
- R6: `task_en[i]` sets enable bit i and `task_dis[i]` clears it at the next edge. When both are high in the same cycle, the enable wins.
- R7: With chain bit i set (`sc_wdata` bit i), a hit on candidate i enables candidate (i+1) mod N. A chained candidate with a higher index is evaluated against the same byte. The wrap from N-1 to 0 takes effect on the next byte.
- R8: With self bit i set (`sc_wdata` bit N+i), a hit on candidate i clears enable bit i.
- R9: When a one-shot or self-shortcut clear and `task_en[i]` fall in the same cycle, candidate i stays enabled.
- R10: `cfg_we` loads the enable bits from `cfg_wdata[N-1:0]` and the one-shot bits from `cfg_wdata[2N-1:N]`. Task pulses in the same cycle are applied on top of the loaded value.
- R11: Bytes on consecutive cycles are each evaluated in order, with each byte seeing the enables left by the one before.
- R12: `irq_mask_we` loads the irq mask from `irq_mask_wdata`, and `cand_we` loads `cand_wdata` into candidate `cand_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A byte is being written to the DMA buffer |
| byte_data | input | 8 | The byte being written |
| rx_count | input | CW | Running receive byte count |
| tx_count | input | CW | Running transmit byte count |
| cfg_we | input | 1 | Load enable and one-shot bits |
| cfg_wdata | input | 2N | {one-shot[N-1:0], enable[N-1:0]} |
| cand_we | input | 1 | Load one candidate value |
| cand_idx | input | IW | Candidate index to load |
| cand_wdata | input | 8 | Candidate value |
| sc_we | input | 1 | Load shortcut bits |
| sc_wdata | input | 2N | {self[N-1:0], chain[N-1:0]} |
| task_en | input | N | Per-candidate enable task pulses |
| task_dis | input | N | Per-candidate disable task pulses |
| evt_clr | input | N | Per-candidate event flag clear |
| irq_mask_we | input | 1 | Load irq mask |
| irq_mask_wdata | input | N | Irq mask value |
| match_en | output | N | Current enable bits |
| evt_pulse | output | N | One-cycle hit pulse per candidate |
| evt_flags | output | N | Sticky event flags |
| rx_amount | output | CW | Receive count latched at the last hit |
| tx_amount | output | CW | Transmit count latched at the last hit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are two collisions: a one-shot clear meeting an enable task in the same cycle, and two bytes arriving on back-to-back cycles.

For the first, the bench drives `task_en` exactly in the ST_APPLY cycle that follows a hitting byte. For the second, it asserts `byte_valid` on two adjacent cycles through a chained sequence, so the second byte depends on enables that the first byte has only just changed.

Two sweeps cover the plain comparison. One runs all 16 enable masks against every candidate value and a non-matching byte. The other runs all 256 byte values against the full bank.

// File: rtl/rx_byte_match_pkg.sv
package rx_byte_match_pkg;
    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_APPLY = 1'b1
    } match_state_e;
endpackage

// File: rtl/rx_byte_match_cands.sv
module rx_byte_match_cands #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_we,
    input  logic [IW-1:0] cand_idx,
    input  logic [DW-1:0] cand_wdata,
    input  logic [DW-1:0] byte_q,
    output logic [N-1:0]  eq
);
    for (genvar i = 0; i < N; i++) begin : g_cand
        logic [DW-1:0] cand_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cand_q <= '0;
            end else if (cand_we && (cand_idx == IW'(i))) begin
                cand_q <= cand_wdata;
            end
        end
        assign eq[i] = (cand_q == byte_q);
    end
endmodule

// File: rtl/rx_byte_match_chain.sv
module rx_byte_match_chain #(
    parameter int N = 4
) (
    input  logic         active,
    input  logic [N-1:0] en_in,
    input  logic [N-1:0] oneshot,
    input  logic [N-1:0] chain,
    input  logic [N-1:0] selfsc,
    input  logic [N-1:0] eq,
    output logic [N-1:0] hits,
    output logic [N-1:0] en_out
);
    always_comb begin
        en_out = en_in;
        hits   = '0;
        if (active) begin
            for (int i = 0; i < N; i++) begin
                if (en_out[i] && eq[i]) begin
                    hits[i] = 1'b1;
                    if (oneshot[i] || selfsc[i]) begin
                        en_out[i] = 1'b0;
                    end
                    if (chain[i]) begin
                        en_out[(i + 1) % N] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_byte_match_events.sv
module rx_byte_match_events #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags  <= '0;
            mask_q <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

    assign irq = |(flags & mask_q);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) & ~$past(clr)) == '0);
endmodule

// File: rtl/rx_byte_match.sv
module rx_byte_match
    import rx_byte_match_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_data,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          cfg_we,
    input  logic [2*N-1:0] cfg_wdata,
    input  logic          cand_we,
    input  logic [IW-1:0] cand_idx,
    input  logic [DW-1:0] cand_wdata,
    input  logic          sc_we,
    input  logic [2*N-1:0] sc_wdata,
    input  logic [N-1:0]  task_en,
    input  logic [N-1:0]  task_dis,
    input  logic [N-1:0]  evt_clr,
    input  logic          irq_mask_we,
    input  logic [N-1:0]  irq_mask_wdata,
    output logic [N-1:0]  match_en,
    output logic [N-1:0]  evt_pulse,
    output logic [N-1:0]  evt_flags,
    output logic [CW-1:0] rx_amount,
    output logic [CW-1:0] tx_amount,
    output logic          irq
);
    match_state_e st_q, st_d;
    logic [DW-1:0] byte_q;
    logic [CW-1:0] rx_cap, tx_cap;
    logic [N-1:0]  en_q, os_q, chain_q, self_q;
    logic [N-1:0]  eq, hits, en_after, en_d, wrap_v;
    logic          active;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT:  st_d = byte_valid ? ST_APPLY : ST_WAIT;
            ST_APPLY: st_d = byte_valid ? ST_APPLY : ST_WAIT;
            default:  st_d = ST_WAIT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        active    = 1'b0;
        evt_pulse = '0;
        unique case (st_q)
            ST_WAIT:  active = 1'b0;
            ST_APPLY: begin
                active    = 1'b1;
                evt_pulse = hits;
            end
            default:  active = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            rx_cap <= '0;
            tx_cap <= '0;
        end else if (byte_valid) begin
            byte_q <= byte_data;
            rx_cap <= rx_count;
            tx_cap <= tx_count;
        end
    end

    rx_byte_match_cands #(.N(N), .DW(DW), .IW(IW)) u_cands (
        .clk(clk), .rst_n(rst_n), .cand_we(cand_we), .cand_idx(cand_idx),
        .cand_wdata(cand_wdata), .byte_q(byte_q), .eq(eq)
    );

    rx_byte_match_chain #(.N(N)) u_chain (
        .active(active), .en_in(en_q), .oneshot(os_q), .chain(chain_q),
        .selfsc(self_q), .eq(eq), .hits(hits), .en_out(en_after)
    );

    rx_byte_match_events #(.N(N)) u_events (
        .clk(clk), .rst_n(rst_n), .set(evt_pulse), .clr(evt_clr),
        .mask_we(irq_mask_we), .mask_wdata(irq_mask_wdata),
        .flags(evt_flags), .irq(irq)
    );

    always_comb begin
        en_d = cfg_we ? cfg_wdata[N-1:0] : en_after;
        en_d = (en_d & ~task_dis) | task_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            os_q      <= '0;
            chain_q   <= '0;
            self_q    <= '0;
            rx_amount <= '0;
            tx_amount <= '0;
        end else begin
            en_q <= en_d;
            if (cfg_we) begin
                os_q <= cfg_wdata[2*N-1:N];
            end
            if (sc_we) begin
                chain_q <= sc_wdata[N-1:0];
                self_q  <= sc_wdata[2*N-1:N];
            end
            if (active && (|hits)) begin
                rx_amount <= rx_cap;
                tx_amount <= tx_cap;
            end
        end
    end

    assign match_en = en_q;
    assign wrap_v   = {{(N-1){1'b0}}, hits[N-1] & chain_q[N-1]};

    // R2
    pulse_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse & ~eq) == '0);
    // R2
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> (evt_pulse == '0));
    // R3
    amount_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (|hits)) |=> (rx_amount == $past(rx_cap)) && (tx_amount == $past(tx_cap)));
    // R4
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cfg_we) |=> (($past(hits & os_q & ~task_en & ~wrap_v) & en_q) == '0));
    // R6
    task_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|task_en) |=> (($past(task_en) & ~en_q) == '0));
endmodule

// File: tb/rx_byte_match_bench.sv
module rx_byte_match_bench;
    localparam int N = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic cfg_we = 1'b0;
    logic [2*N-1:0] cfg_wdata = '0;
    logic cand_we = 1'b0;
    logic [1:0] cand_idx = '0;
    logic [7:0] cand_wdata = '0;
    logic sc_we = 1'b0;
    logic [2*N-1:0] sc_wdata = '0;
    logic [N-1:0] task_en = '0, task_dis = '0, evt_clr = '0;
    logic irq_mask_we = 1'b0;
    logic [N-1:0] irq_mask_wdata = '0;
    logic [N-1:0] match_en, evt_pulse, evt_flags;
    logic [CW-1:0] rx_amount, tx_amount;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] exp_rx = '0, exp_tx = '0;

    always #5 clk = ~clk;

    rx_byte_match u_rx_byte_match (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .rx_count(rx_count), .tx_count(tx_count), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cand_we(cand_we), .cand_idx(cand_idx), .cand_wdata(cand_wdata),
        .sc_we(sc_we), .sc_wdata(sc_wdata), .task_en(task_en), .task_dis(task_dis),
        .evt_clr(evt_clr), .irq_mask_we(irq_mask_we), .irq_mask_wdata(irq_mask_wdata),
        .match_en(match_en), .evt_pulse(evt_pulse), .evt_flags(evt_flags),
        .rx_amount(rx_amount), .tx_amount(tx_amount), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic [N-1:0] os, input logic [N-1:0] en);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = {os, en};
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic shortcuts(input logic [N-1:0] sf, input logic [N-1:0] ch);
        @(negedge clk); sc_we = 1'b1; sc_wdata = {sf, ch};
        @(negedge clk); sc_we = 1'b0;
    endtask

    task automatic cand(input int i, input logic [7:0] v);
        @(negedge clk); cand_we = 1'b1; cand_idx = 2'(i); cand_wdata = v;
        @(negedge clk); cand_we = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); evt_clr = '1;
        @(negedge clk); evt_clr = '0;
    endtask

    // sends one byte; returns pulse seen in the evaluation cycle
    task automatic send(input logic [7:0] b, output logic [N-1:0] pulse);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b;
        rx_count = rx_count + 1; tx_count = tx_count + 3;
        @(negedge clk);
        byte_valid = 1'b0;
        pulse = evt_pulse;
        if (pulse != '0) begin
            exp_rx = rx_count; exp_tx = tx_count;
        end
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] p;
        repeat (3) @(negedge clk);
        check("R1 en", 32'(match_en), 0);
        check("R1 flags", 32'(evt_flags), 0);
        check("R1 pulse", 32'(evt_pulse), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 amounts", {rx_amount, tx_amount}, 0);
        rst_n = 1'b1;

        // R12: program candidates 0x11,0x22,0x33,0x44
        for (int j = 0; j < N; j++) cand(j, 8'(8'h11 * (j + 1)));
        shortcuts('0, '0);

        // R2/R3/R10 sweep all enable masks
        for (int m = 0; m < 16; m++) begin
            cfg('0, 4'(m));
            check("R10 en load", 32'(match_en), m);
            clear_flags();
            for (int j = 0; j <= N; j++) begin
                logic [7:0] b;
                logic [N-1:0] e;
                logic [CW-1:0] prx, ptx;
                b = (j == N) ? 8'h55 : 8'(8'h11 * (j + 1));
                e = (j == N) ? '0 : (4'(m) & (4'b1 << j));
                prx = exp_rx; ptx = exp_tx;
                send(b, p);
                check("R2 sweep pulse", 32'(p), 32'(e));
                if (e == '0) check("R3 no hit keeps amount", {rx_amount, tx_amount}, {prx, ptx});
                else check("R3 amount", {rx_amount, tx_amount}, {rx_count, tx_count});
            end
            check("R5 flags sweep", 32'(evt_flags), m);
            check("R2 enables unchanged", 32'(match_en), m);
        end

        // R2 full byte sweep, all enabled
        cfg('0, 4'hF);
        for (int b = 0; b < 256; b++) begin
            logic [N-1:0] e;
            e = '0;
            for (int j = 0; j < N; j++) if (b == 8'h11 * (j + 1)) e[j] = 1'b1;
            send(8'(b), p);
            check("R2 byte sweep", 32'(p), 32'(e));
        end

        // R4 one-shot
        cfg(4'b0010, 4'b0011);
        send(8'h22, p);
        check("R4 pulse", 32'(p), 32'b0010);
        check("R4 cleared", 32'(match_en), 32'b0001);
        send(8'h22, p);
        check("R4 no second hit", 32'(p), 0);

        // R5 irq masking and clear
        clear_flags();
        @(negedge clk); irq_mask_we = 1'b1; irq_mask_wdata = 4'b0100;
        @(negedge clk); irq_mask_we = 1'b0;
        cfg('0, 4'hF);
        send(8'h11, p);
        check("R5 irq masked", 32'(irq), 0);
        send(8'h33, p);
        check("R5 irq set", 32'(irq), 1);
        check("R5 flags held", 32'(evt_flags), 32'b0101);
        @(negedge clk); evt_clr = 4'b0100;
        @(negedge clk); evt_clr = '0;
        check("R5 irq cleared", 32'(irq), 0);
        check("R5 flag cleared", 32'(evt_flags), 32'b0001);

        // R6 tasks
        cfg('0, '0);
        @(negedge clk); task_en = 4'b1010;
        @(negedge clk); task_en = '0;
        check("R6 enable task", 32'(match_en), 32'b1010);
        @(negedge clk); task_dis = 4'b0010;
        @(negedge clk); task_dis = '0;
        check("R6 disable task", 32'(match_en), 32'b1000);
        @(negedge clk); task_en = 4'b0100; task_dis = 4'b0100;
        @(negedge clk); task_en = '0; task_dis = '0;
        check("R6 enable wins", 32'(match_en), 32'b1100);

        // R7 chain sequence detector 0x11 -> 0x22 -> 0x33
        cfg(4'b0111, 4'b0001);
        shortcuts('0, 4'b0011);
        clear_flags();
        send(8'h22, p);
        check("R7 not yet armed", 32'(p), 0);
        send(8'h11, p);
        check("R7 step0", 32'(p), 32'b0001);
        check("R7 armed next", 32'(match_en), 32'b0010);
        send(8'h22, p);
        check("R7 step1", 32'(p), 32'b0010);
        send(8'h33, p);
        check("R7 step2", 32'(p), 32'b0100);
        check("R7 all done", 32'(match_en), 0);

        // R7 same-byte chaining with duplicate candidates
        cand(1, 8'h11);
        cfg('0, 4'b0001);
        shortcuts('0, 4'b0001);
        send(8'h11, p);
        check("R7 same byte chain", 32'(p), 32'b0011);
        cand(1, 8'h22);

        // R7 wrap N-1 -> 0, next byte
        cand(0, 8'h44);
        cfg(4'b1000, 4'b1000);
        shortcuts('0, 4'b1000);
        send(8'h44, p);
        check("R7 wrap same byte", 32'(p), 32'b1000);
        check("R7 wrap enables 0", 32'(match_en), 32'b0001);
        send(8'h44, p);
        check("R7 wrap next byte", 32'(p), 32'b0001);
        cand(0, 8'h11);

        // R8 self shortcut
        cfg('0, 4'b0100);
        shortcuts(4'b0100, '0);
        send(8'h33, p);
        check("R8 self pulse", 32'(p), 32'b0100);
        check("R8 self clears", 32'(match_en), 0);
        shortcuts('0, '0);

        // R9 task enable in the evaluation cycle of a one-shot hit
        cfg(4'b0001, 4'b0001);
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h11;
        @(negedge clk); byte_valid = 1'b0; task_en = 4'b0001;
        check("R9 pulse", 32'(evt_pulse), 32'b0001);
        @(negedge clk); task_en = '0;
        check("R9 enable wins", 32'(match_en), 32'b0001);

        // R11 back-to-back bytes through a chain
        cfg(4'b0011, 4'b0001);
        shortcuts('0, 4'b0001);
        clear_flags();
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h11;
        @(negedge clk); byte_data = 8'h22;
        check("R11 first pulse", 32'(evt_pulse), 32'b0001);
        @(negedge clk); byte_valid = 1'b0;
        check("R11 second pulse", 32'(evt_pulse), 32'b0010);
        @(negedge clk);
        check("R11 flags", 32'(evt_flags), 32'b0011);
        check("R11 enables", 32'(match_en), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule